// File: doc/BRIEF.md
# Serial Transmit Channel with Line-Break Control

This block is the transmit half of an asynchronous serial port. Bytes written by the host go into an eight-entry queue. A shifter sends them on `txd_o` as 8N1 frames: a low start bit, eight data bits least significant first, and a high stop bit. Each bit lasts sixteen strobes of an externally supplied 16x rate tick. Queued characters follow each other with no idle gap.

Four single-cycle command strobes control the channel:

- **Enable** turns the transmitter on. `tx_rdy_o` and `tx_emt_o` then report it.
- **Disable** turns it off in an orderly way. Status drops at once, new writes are refused, and whatever is already queued is still sent.
- **Start-break** holds the line low. The low level begins only after every queued character has gone out.
- **Stop-break** releases the line. At least one full bit time of marking is guaranteed before the next character starts.

All line changes in break handling and framing happen on bit-time boundaries. These boundaries come from a free-running divide-by-16 of the tick, which keeps entry into and exit from break within two bit times.

Top module: `uart_tx_brk`

## Requirements
- R1: After reset `txd_o` is high, and `tx_rdy_o`, `tx_emt_o` and `wr_ovf_o` are low. The transmitter starts disabled.
- R2: One cycle after an enable strobe with an empty queue, both `tx_rdy_o` and `tx_emt_o` are high. `tx_emt_o` is never high while `tx_rdy_o` is low.
- R3: Each byte is sent as a low start bit, then data bits 0 through 7, then a high stop bit. Every bit is 16 tick strobes long. A queued byte starts in the bit time right after the previous stop bit.
- R4: `tx_emt_o` goes low in the cycle after a write is accepted. It returns high once the stop bit of the last queued byte has ended. `tx_rdy_o` is high exactly when the channel is enabled and the queue has room.
- R5: The queue holds 8 bytes. With 8 unsent bytes, `tx_rdy_o` is low. A further write is dropped and sets `wr_ovf_o`, which stays high until reset.
- R6: A write is rejected, and never transmitted, while the channel is disabled. This includes the period in which a disable is still draining the queue.
- R7: After a start-break, `txd_o` goes low only once all queued bytes have been fully sent. From an idle, empty channel the low level starts within two bit times (32 ticks).
- R8: A start-break strobe is ignored while the channel is disabled. It is not remembered for a later enable.
- R9: After a stop-break, `txd_o` is high within two bit times. It stays high for at least one full bit time before the next start bit.
- R10: A disable strobe drops `tx_rdy_o` and `tx_emt_o` in the next cycle and cancels any break. Bytes already queued are still sent in full, after which the line idles high.
- R11: When enable and disable arrive in the same cycle, disable wins. When start-break and stop-break arrive in the same cycle, stop-break wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | 16x bit-rate strobe |
| wr_en_i | input | 1 | Write strobe for the queue |
| wr_data_i | input | 8 | Byte to queue |
| cmd_enable_i | input | 1 | Enable command strobe |
| cmd_disable_i | input | 1 | Disable command strobe |
| cmd_brk_start_i | input | 1 | Start-break command strobe |
| cmd_brk_stop_i | input | 1 | Stop-break command strobe |
| txd_o | output | 1 | Serial line, idle high |
| tx_rdy_o | output | 1 | Enabled and queue has room |
| tx_emt_o | output | 1 | Enabled, queue empty and shifter idle |
| wr_ovf_o | output | 1 | Sticky flag for a write dropped on a full queue |

## Verification
Two pairs of commands can collide in one cycle. The bench drives both commands of each pair on the same cycle, with no bus timing in between.

- **Enable with disable:** the pair is issued on a disabled channel. The check is that `tx_rdy_o` stays low.
- **Start-break with stop-break:** the pair is issued on an enabled, idle channel. The check is that `txd_o` stays high for three bit times.

A second kind of overlap comes from a start-break issued while two bytes are still queued. A receiver model in the bench must decode both bytes cleanly before it sees the line held low.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_BRK   = 2'd2,
    ST_MARK  = 2'd3
  } tx_st_e;
endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  logic [DW-1:0]                data_i,
  input  logic                         pop_i,
  output logic [DW-1:0]                data_o,
  output logic                         full_o,
  output logic                         empty_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign data_o  = mem_q[rd_ptr_q];
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;

  a_r5_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_i);
  a_r3_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !pop_i);
endmodule

// File: rtl/uart_tx_bittmr.sv
module uart_tx_bittmr #(
  parameter int OVS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic bit_tick_o
);
  localparam int CW = $clog2(OVS);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = (cnt_q == CW'(OVS-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  assign bit_tick_o = tick_i && wrap;
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_tick_i,
  input  logic          brk_req_i,
  input  logic          fifo_empty_i,
  input  logic [DW-1:0] fifo_data_i,
  output logic          pop_o,
  output logic          busy_o,
  output logic          txd_o
);
  localparam int FRAME = DW + 2;
  localparam int IW    = $clog2(FRAME);

  tx_st_e           st_q, st_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic [FRAME-1:0] sh_q, sh_d;
  logic             load;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    load  = 1'b0;
    if (bit_tick_i) begin
      if (st_q == ST_SHIFT && idx_q != IW'(FRAME-1)) begin
        idx_d = idx_q + 1'b1;
        sh_d  = {1'b1, sh_q[FRAME-1:1]};
      end else if (st_q == ST_BRK) begin
        if (!brk_req_i) st_d = ST_MARK;
      end else begin
        // frame boundary: queued data first, then break, else idle
        if (!fifo_empty_i) begin
          load  = 1'b1;
          st_d  = ST_SHIFT;
          idx_d = '0;
          sh_d  = {1'b1, fifo_data_i, 1'b0};
        end else if (brk_req_i) begin
          st_d = ST_BRK;
        end else begin
          st_d = ST_IDLE;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      sh_q  <= '1;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
    end
  end

  assign pop_o  = load;
  assign busy_o = (st_q == ST_SHIFT);
  assign txd_o  = (st_q == ST_SHIFT) ? sh_q[0] : (st_q != ST_BRK);

  a_r3_state_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != $past(st_q)) |-> $past(bit_tick_i));
  a_r7_brk_needs_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BRK && $past(st_q) != ST_BRK) |-> $past(fifo_empty_i));
  a_r9_mark_after_brk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) == ST_BRK && st_q != ST_BRK) |-> st_q == ST_MARK);
  a_r9_mark_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_MARK) |-> txd_o);
endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int OVS   = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick16_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          cmd_enable_i,
  input  logic          cmd_disable_i,
  input  logic          cmd_brk_start_i,
  input  logic          cmd_brk_stop_i,
  output logic          txd_o,
  output logic          tx_rdy_o,
  output logic          tx_emt_o,
  output logic          wr_ovf_o
);
  localparam int CW = $clog2(DEPTH+1);

  logic          en_q, brk_q, ovf_q;
  logic          bit_tick, push, pop, full, empty, busy;
  logic [DW-1:0] head;
  logic [CW-1:0] count;

  assign push = wr_en_i && en_q && !full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      brk_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (cmd_disable_i)     en_q <= 1'b0;
      else if (cmd_enable_i) en_q <= 1'b1;
      if (cmd_disable_i || cmd_brk_stop_i) brk_q <= 1'b0;
      else if (cmd_brk_start_i && en_q)    brk_q <= 1'b1;
      if (wr_en_i && en_q && full) ovf_q <= 1'b1;
    end
  end

  uart_tx_bittmr #(.OVS(OVS)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick16_i),
    .bit_tick_o (bit_tick)
  );

  uart_tx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  (wr_data_i),
    .pop_i   (pop),
    .data_o  (head),
    .full_o  (full),
    .empty_o (empty),
    .count_o (count)
  );

  uart_tx_shift #(.DW(DW)) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_tick_i   (bit_tick),
    .brk_req_i    (brk_q),
    .fifo_empty_i (empty),
    .fifo_data_i  (head),
    .pop_o        (pop),
    .busy_o       (busy),
    .txd_o        (txd_o)
  );

  assign tx_rdy_o = en_q && !full;
  assign tx_emt_o = en_q && empty && !busy;
  assign wr_ovf_o = ovf_q;

  a_r2_emt_implies_rdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_emt_o |-> tx_rdy_o);
  a_r6_no_growth_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!en_q) |-> count <= $past(count));
  a_r5_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_ovf_o) |-> wr_ovf_o);
endmodule

// File: tb/uart_tx_brk_tb.sv
module uart_tx_brk_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       c_en = 1'b0, c_dis = 1'b0, c_bs = 1'b0, c_bp = 1'b0;
  logic       txd, rdy, emt, ovf;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  uart_tx_brk u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .cmd_enable_i(c_en), .cmd_disable_i(c_dis),
    .cmd_brk_start_i(c_bs), .cmd_brk_stop_i(c_bp), .txd_o(txd),
    .tx_rdy_o(rdy), .tx_emt_o(emt), .wr_ovf_o(ovf)
  );

  // {data written, data expected on the line}
  localparam logic [15:0] VEC [6] = '{
    16'h5555, 16'hA5A5, 16'h0000, 16'hFFFF, 16'h8181, 16'h3C3C
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input int which);
    case (which)
      0: c_en = 1'b1;
      1: c_dis = 1'b1;
      2: c_bs = 1'b1;
      default: c_bp = 1'b1;
    endcase
    @(negedge clk);
    c_en = 1'b0; c_dis = 1'b0; c_bs = 1'b0; c_bp = 1'b0;
  endtask

  // counts low samples over n cycles
  task automatic count_low(input int n, output int lows);
    lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!txd) lows++;
    end
  endtask

  // line receiver model: waits for start, samples mid-bit
  task automatic rx_byte(output logic [7:0] d, output bit ok, output int hi_cnt);
    bit found = 1'b0;
    bit st_low;
    hi_cnt = 0; d = '0;
    while (!found && hi_cnt < 2000) begin
      @(negedge clk);
      if (!txd) found = 1'b1;
      else hi_cnt++;
    end
    repeat (7) @(negedge clk);
    st_low = !txd;
    for (int i = 0; i < 8; i++) begin
      repeat (16) @(negedge clk);
      d[i] = txd;
    end
    repeat (16) @(negedge clk);
    ok = found && st_low && txd;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    bit ok;
    int hc, lows, c1;

    repeat (3) @(negedge clk);
    check(txd && !rdy && !emt && !ovf, "R1 reset outputs",
          {txd, rdy, emt, ovf}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);

    // writes and break while disabled
    wr(8'hA5);
    pulse(2);
    pulse(0);
    check(rdy && emt, "R2 enable status", {rdy, emt}, 2'b11);
    count_low(48, lows);
    check(lows == 0, "R6 disabled write not sent", lows, 0);
    check(lows == 0, "R8 break while disabled ignored", lows, 0);

    // vector table, back to back
    foreach (VEC[k]) wr(VEC[k][15:8]);
    check(!emt, "R4 emt low after write", emt, 0);
    foreach (VEC[k]) begin
      rx_byte(d, ok, hc);
      check(ok && d == VEC[k][7:0], "R3 frame data", d, VEC[k][7:0]);
      if (k > 0) check(hc <= 9, "R3 no idle gap", hc, 8);
    end
    repeat (24) @(negedge clk);
    check(emt && rdy, "R4 emt after last stop", {emt, rdy}, 2'b11);

    // break waits for queued bytes
    wr(8'h96); wr(8'h69);
    pulse(2);
    rx_byte(d, ok, hc);
    check(ok && d == 8'h96, "R7 first queued byte intact", d, 8'h96);
    rx_byte(d, ok, hc);
    check(ok && d == 8'h69, "R7 second queued byte intact", d, 8'h69);
    repeat (24) @(negedge clk);
    check(!txd, "R7 break after drain", txd, 0);
    count_low(64, lows);
    check(lows == 64, "R7 break held", lows, 64);

    // stop break with a byte waiting
    c_bp = 1'b1; wr_en = 1'b1; wr_data = 8'h3C;
    @(negedge clk);
    c_bp = 1'b0; wr_en = 1'b0;
    c1 = 1;
    while (!txd && c1 < 64) begin @(negedge clk); c1++; end
    check(c1 <= 32, "R9 release within two bits", c1, 32);
    rx_byte(d, ok, hc);
    check(hc >= 15, "R9 marking bit before next", hc, 15);
    check(ok && d == 8'h3C, "R9 byte after break", d, 8'h3C);
    repeat (24) @(negedge clk);

    // fill queue with tick frozen
    tick = 1'b0;
    for (int i = 0; i < 8; i++) wr(8'(8'h10 + i));
    check(!rdy && !ovf, "R5 full clears rdy", {rdy, ovf}, 2'b00);
    wr(8'hEE);
    check(ovf, "R5 overflow flag", ovf, 1);
    tick = 1'b1;
    for (int i = 0; i < 8; i++) begin
      rx_byte(d, ok, hc);
      check(ok && d == 8'(8'h10 + i), "R5 queued byte", d, 8'h10 + i);
    end
    count_low(48, lows);
    check(lows == 0, "R5 dropped byte not sent", lows, 0);
    check(ovf, "R5 overflow sticky", ovf, 1);

    // start and stop in same cycle
    c_bs = 1'b1; c_bp = 1'b1;
    @(negedge clk);
    c_bs = 1'b0; c_bp = 1'b0;
    count_low(48, lows);
    check(lows == 0, "R11 stop beats start", lows, 0);

    // idle break start latency
    pulse(2);
    c1 = 1;
    while (txd && c1 < 64) begin @(negedge clk); c1++; end
    check(c1 <= 32, "R7 idle break within two bits", c1, 32);
    pulse(3);
    repeat (48) @(negedge clk);

    // disable drains queue
    wr(8'h11); wr(8'h22); wr(8'h33);
    pulse(1);
    check(!rdy && !emt, "R10 status drops on disable", {rdy, emt}, 2'b00);
    wr(8'h77);
    for (int i = 0; i < 3; i++) begin
      rx_byte(d, ok, hc);
      check(ok && d == 8'(8'h11 * (i + 1)), "R10 drained byte", d, 8'h11 * (i + 1));
    end
    count_low(64, lows);
    check(lows == 0, "R6 write during drain rejected", lows, 0);

    // enable and disable in same cycle
    c_en = 1'b1; c_dis = 1'b1;
    @(negedge clk);
    c_en = 1'b0; c_dis = 1'b0;
    check(!rdy && !emt, "R11 disable beats enable", {rdy, emt}, 2'b00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule